// File: doc/BRIEF.md
# NAND Device Probe and Parameter Page Sequencer

This block brings up an 8-bit NAND device with no software help. A host pulses a start request. The block then resets the device and waits for it to report ready. It reads the device identifier and checks it against a short list of known parts. It then looks for the standard parameter-page signature. When the signature is present, it streams the parameter page and keeps the geometry fields the system needs.

The NAND pins are driven by a small bus-cycle engine. Each command, address or data read takes three clock cycles: request, strobe low, strobe high. A status-poll submodule borrows the same engine for every ready wait. The decoded fields are written straight into the output registers as the page bytes go past, so no copy of the page is stored. When the sequence ends, a one-cycle done pulse is raised together with a found flag and a signature-valid flag.

Top module: `nand_probe_seq`

## Requirements
- R1: After reset, done_o, found_o, onfi_o and every field output are 0, both strobes are high (inactive), and the command and address latch enables are low.
- R2: A start accepted while idle clears found_o, onfi_o and all field outputs in the next cycle. A start that arrives while a probe is running is ignored.
- R3: The first bus operation of every probe is the command byte 0xFF.
- R4: A status poll issues command 0x70 and reads status bytes until bit 6 is 1, up to POLL_READS reads. It is OK only when bit 6 is 1 and bit 0 is 0. After the reset command, up to RESET_POLLS polls are run, and the first OK poll ends the loop.
- R5: After an OK poll, the block issues command 0x90 with address 0x00 and reads four bytes. The second byte is compared with the KNOWN_IDS list. If the polls never succeed, this read is skipped.
- R6: The signature check issues command 0x90 with address 0x20 and reads four bytes. The signature is present only if the bytes are 0x4F, 0x4E, 0x46, 0x49 in that order. Without the signature, no parameter page is requested and onfi_o is 0.
- R7: The parameter page is read with this sequence: command 0xEC, address 0x00, one status poll, command 0x00, then exactly PAGE_LEN (116) data reads.
- R8: Fields are taken from these byte offsets, with multi-byte fields little-endian:
  - maker code: 64
  - bus width: bit 0 of byte 6
  - data bytes per page: 80..83
  - spare bytes per page: 84..85
  - pages per block: 92..95
  - blocks per unit: 96..99
  - unit count: 100
  - ECC bits: 112
  - model: 49
- R9: If all PAGE_LEN bytes read are 0xFF, the page is invalid. In that case onfi_o is 0 and all field outputs are 0 at done.
- R10: At done, found_o is 1 when the ID byte matched the list, or when the signature was present and the page was valid.
- R11: The write and read strobes are never low together. The command and address latch enables are never high together. The data bus is not driven while the read strobe is low.
- R12: done_o is high for exactly one cycle per probe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Probe request, taken when idle |
| done_o | output | 1 | One-cycle end-of-probe pulse |
| found_o | output | 1 | Device detected |
| onfi_o | output | 1 | Signature present and parameter page valid |
| mfr_id_o | output | 8 | Maker code |
| bus16_o | output | 1 | Device bus is 16 bits wide |
| page_bytes_o | output | 32 | Data bytes per page |
| spare_bytes_o | output | 16 | Spare bytes per page |
| pages_per_blk_o | output | 32 | Pages per block |
| blks_per_lun_o | output | 32 | Blocks per logical unit |
| lun_cnt_o | output | 8 | Logical unit count |
| ecc_bits_o | output | 8 | ECC correction bits |
| model_o | output | 8 | Model byte |
| nand_dq_o | output | 8 | Data driven to the device |
| nand_dq_i | input | 8 | Data from the device |
| nand_dq_oe_o | output | 1 | Data output enable |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Write strobe, active low |
| nand_re_no | output | 1 | Read strobe, active low |

## Verification
A new start request can land in the same cycle as the done pulse of the probe that is just ending. In that cycle the block has returned to idle, so the request is taken at the next edge, while the end-of-probe flags are still on the outputs.

The bench provokes this by holding start high through a whole probe. That run must finish with one reset command and a single done pulse. One edge after done, found_o and the field outputs must read zero, and a second reset command must then appear on the bus.

// File: rtl/nand_probe_pkg.sv
package nand_probe_pkg;

  localparam int unsigned DQ_W = 8;

  typedef enum logic [1:0] {BUS_CMD, BUS_ADDR, BUS_READ} bus_kind_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RST_CMD, ST_RST_POLL, ST_ID_CMD, ST_ID_ADDR, ST_ID_RD,
    ST_SIG_CMD, ST_SIG_ADDR, ST_SIG_RD, ST_PP_CMD, ST_PP_ADDR, ST_PP_POLL,
    ST_PP_DOUT, ST_PP_RD, ST_FINISH
  } probe_st_e;

  typedef struct packed {
    logic [7:0]  mfr;
    logic        bus16;
    logic [31:0] page_bytes;
    logic [15:0] spare_bytes;
    logic [31:0] pages_per_blk;
    logic [31:0] blks_per_lun;
    logic [7:0]  lun_cnt;
    logic [7:0]  ecc_bits;
    logic [7:0]  model;
  } geom_t;

  localparam logic [7:0] OP_RESET  = 8'hFF;
  localparam logic [7:0] OP_STATUS = 8'h70;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PARAM  = 8'hEC;
  localparam logic [7:0] OP_DOUT   = 8'h00;
  localparam logic [7:0] AD_ID     = 8'h00;
  localparam logic [7:0] AD_SIG    = 8'h20;

  localparam int unsigned OFF_BUSW  = 6;
  localparam int unsigned OFF_MODEL = 49;
  localparam int unsigned OFF_MFR   = 64;
  localparam int unsigned OFF_PAGE  = 80;
  localparam int unsigned OFF_SPARE = 84;
  localparam int unsigned OFF_PPB   = 92;
  localparam int unsigned OFF_BPL   = 96;
  localparam int unsigned OFF_LUNS  = 100;
  localparam int unsigned OFF_ECC   = 112;

endpackage

// File: rtl/nand_bus_cycle.sv
module nand_bus_cycle
  import nand_probe_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  bus_kind_e       kind_i,
  input  logic [DQ_W-1:0] wdata_i,
  output logic            ack_o,
  output logic [DQ_W-1:0] rdata_o,
  output logic [DQ_W-1:0] dq_o,
  input  logic [DQ_W-1:0] dq_i,
  output logic            dq_oe_o,
  output logic            cle_o,
  output logic            ale_o,
  output logic            we_no,
  output logic            re_no
);
  typedef enum logic [1:0] {B_IDLE, B_LOW, B_HIGH} bst_e;

  bst_e            st_q;
  bus_kind_e       kind_q;
  logic [DQ_W-1:0] wdata_q, rdata_q;
  logic            active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= B_IDLE;
      kind_q  <= BUS_READ;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      case (st_q)
        B_IDLE: if (req_i) begin
          kind_q  <= kind_i;
          wdata_q <= wdata_i;
          st_q    <= B_LOW;
        end
        B_LOW: begin
          if (kind_q == BUS_READ) rdata_q <= dq_i;
          st_q <= B_HIGH;
        end
        default: st_q <= B_IDLE;
      endcase
    end
  end

  assign active  = (st_q != B_IDLE);
  assign ack_o   = (st_q == B_HIGH);
  assign rdata_o = rdata_q;
  assign dq_o    = wdata_q;
  assign dq_oe_o = active && (kind_q != BUS_READ);
  assign cle_o   = active && (kind_q == BUS_CMD);
  assign ale_o   = active && (kind_q == BUS_ADDR);
  assign we_no   = !((st_q == B_LOW) && (kind_q != BUS_READ));
  assign re_no   = !((st_q == B_LOW) && (kind_q == BUS_READ));
endmodule

// File: rtl/nand_status_poll.sv
module nand_status_poll
  import nand_probe_pkg::*;
#(
  parameter int unsigned POLL_READS = 1000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  output logic            req_o,
  output bus_kind_e       kind_o,
  output logic [DQ_W-1:0] wdata_o,
  input  logic            ack_i,
  input  logic            rdy_i,
  input  logic            fail_i,
  output logic            done_o,
  output logic            ok_o
);
  localparam int unsigned RD_W = $clog2(POLL_READS + 1);

  typedef enum logic [1:0] {P_IDLE, P_CMD, P_READ} pst_e;

  pst_e            st_q;
  logic            inflt_q;
  logic [RD_W-1:0] rd_cnt_q;

  assign req_o   = (st_q != P_IDLE) && !inflt_q;
  assign kind_o  = (st_q == P_CMD) ? BUS_CMD : BUS_READ;
  assign wdata_o = OP_STATUS;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= P_IDLE;
      inflt_q  <= 1'b0;
      rd_cnt_q <= '0;
      done_o   <= 1'b0;
      ok_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (req_o) inflt_q <= 1'b1;
      case (st_q)
        P_IDLE: if (start_i) begin
          st_q     <= P_CMD;
          rd_cnt_q <= '0;
        end
        P_CMD: if (ack_i) begin
          inflt_q <= 1'b0;
          st_q    <= P_READ;
        end
        default: if (ack_i) begin
          inflt_q <= 1'b0;
          if (rdy_i) begin
            done_o <= 1'b1;
            ok_o   <= !fail_i;
            st_q   <= P_IDLE;
          end else if (rd_cnt_q == RD_W'(POLL_READS - 1)) begin
            done_o <= 1'b1;
            ok_o   <= 1'b0;
            st_q   <= P_IDLE;
          end else begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/nand_param_capture.sv
module nand_param_capture
  import nand_probe_pkg::*;
#(
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DQ_W-1:0]  byte_i,
  output geom_t            geom_o
);
  localparam int unsigned WD_W = IDX_W - 2;

  logic [WD_W-1:0] word;
  logic [1:0]      lane;

  assign word = idx_i[IDX_W-1:2];
  assign lane = idx_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      geom_o <= '0;
    end else if (clr_i) begin
      geom_o <= '0;
    end else if (wr_i) begin
      if (idx_i == IDX_W'(OFF_BUSW))  geom_o.bus16    <= byte_i[0];
      if (idx_i == IDX_W'(OFF_MODEL)) geom_o.model    <= byte_i;
      if (idx_i == IDX_W'(OFF_MFR))   geom_o.mfr      <= byte_i;
      if (idx_i == IDX_W'(OFF_LUNS))  geom_o.lun_cnt  <= byte_i;
      if (idx_i == IDX_W'(OFF_ECC))   geom_o.ecc_bits <= byte_i;
      // 4-byte fields sit on 4-byte boundaries; low index bits pick the lane
      if (word == WD_W'(OFF_PAGE / 4)) geom_o.page_bytes[8*lane +: 8]    <= byte_i;
      if (word == WD_W'(OFF_PPB / 4))  geom_o.pages_per_blk[8*lane +: 8] <= byte_i;
      if (word == WD_W'(OFF_BPL / 4))  geom_o.blks_per_lun[8*lane +: 8]  <= byte_i;
      if (word == WD_W'(OFF_SPARE / 4) && !lane[1])
        geom_o.spare_bytes[8*lane[0] +: 8] <= byte_i;
    end
  end
endmodule

// File: rtl/nand_probe_seq.sv
module nand_probe_seq
  import nand_probe_pkg::*;
#(
  parameter int unsigned POLL_READS  = 1000,
  parameter int unsigned RESET_POLLS = 60,
  parameter int unsigned PAGE_LEN    = 116,
  parameter int unsigned N_IDS       = 4,
  parameter logic [N_IDS*8-1:0] KNOWN_IDS = {8'hDA, 8'hF1, 8'hDC, 8'hA1}
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  output logic        done_o,
  output logic        found_o,
  output logic        onfi_o,
  output logic [7:0]  mfr_id_o,
  output logic        bus16_o,
  output logic [31:0] page_bytes_o,
  output logic [15:0] spare_bytes_o,
  output logic [31:0] pages_per_blk_o,
  output logic [31:0] blks_per_lun_o,
  output logic [7:0]  lun_cnt_o,
  output logic [7:0]  ecc_bits_o,
  output logic [7:0]  model_o,
  output logic [7:0]  nand_dq_o,
  input  logic [7:0]  nand_dq_i,
  output logic        nand_dq_oe_o,
  output logic        nand_cle_o,
  output logic        nand_ale_o,
  output logic        nand_we_no,
  output logic        nand_re_no
);
  localparam int unsigned CNT_W = $clog2(PAGE_LEN);
  localparam int unsigned ATT_W = $clog2(RESET_POLLS + 1);

  probe_st_e        st_q;
  logic             inflt_q, poll_run_q;
  logic [CNT_W-1:0] cnt_q;
  logic [ATT_W-1:0] att_q;
  logic [7:0]       id_byte_q;
  logic             id_seen_q, sig_ok_q, all_ff_q;
  logic             busy;

  logic             is_op, is_poll, seq_req, poll_start;
  bus_kind_e        seq_kind;
  logic [DQ_W-1:0]  seq_wdata;

  logic             bus_req, bus_ack;
  bus_kind_e        bus_kind;
  logic [DQ_W-1:0]  bus_wdata, bus_rdata;

  logic             p_req, p_done, p_ok;
  bus_kind_e        p_kind;
  logic [DQ_W-1:0]  p_wdata;

  logic             cap_clr, cap_wr;
  geom_t            geom;
  logic [N_IDS-1:0] id_eq;
  logic             id_hit, sig_ok_nx, all_ff_nx, last_sig, last_page;

  function automatic logic [7:0] sig_char(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h4F;
      2'd1:    return 8'h4E;
      2'd2:    return 8'h46;
      default: return 8'h49;
    endcase
  endfunction

  for (genvar g = 0; g < N_IDS; g++) begin : g_id
    assign id_eq[g] = id_seen_q && (id_byte_q == KNOWN_IDS[8*g +: 8]);
  end
  assign id_hit = |id_eq;

  assign busy    = (st_q != ST_IDLE);
  assign is_poll = (st_q == ST_RST_POLL) || (st_q == ST_PP_POLL);
  assign is_op   = busy && !is_poll && (st_q != ST_FINISH);
  assign seq_req = is_op && !inflt_q;
  assign poll_start = is_poll && !poll_run_q;

  always_comb begin
    seq_kind  = BUS_READ;
    seq_wdata = OP_DOUT;
    case (st_q)
      ST_RST_CMD:                seq_kind = BUS_CMD;
      ST_ID_CMD, ST_SIG_CMD:     begin seq_kind = BUS_CMD;  seq_wdata = OP_IDENT; end
      ST_ID_ADDR:                begin seq_kind = BUS_ADDR; seq_wdata = AD_ID;    end
      ST_SIG_ADDR:               begin seq_kind = BUS_ADDR; seq_wdata = AD_SIG;   end
      ST_PP_CMD:                 begin seq_kind = BUS_CMD;  seq_wdata = OP_PARAM; end
      ST_PP_ADDR:                seq_kind = BUS_ADDR;
      ST_PP_DOUT:                seq_kind = BUS_CMD;
      default:                   ;
    endcase
    if (st_q == ST_RST_CMD) seq_wdata = OP_RESET;
  end

  assign bus_req   = is_poll ? p_req   : seq_req;
  assign bus_kind  = is_poll ? p_kind  : seq_kind;
  assign bus_wdata = is_poll ? p_wdata : seq_wdata;

  assign sig_ok_nx = sig_ok_q && (bus_rdata == sig_char(cnt_q[1:0]));
  assign all_ff_nx = all_ff_q && (bus_rdata == 8'hFF);
  assign last_sig  = (cnt_q == CNT_W'(3));
  assign last_page = (cnt_q == CNT_W'(PAGE_LEN - 1));

  assign cap_wr  = (st_q == ST_PP_RD) && bus_ack;
  assign cap_clr = ((st_q == ST_IDLE) && start_i) ||
                   ((st_q == ST_FINISH) && !(sig_ok_q && !all_ff_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      inflt_q    <= 1'b0;
      poll_run_q <= 1'b0;
      cnt_q      <= '0;
      att_q      <= '0;
      id_byte_q  <= '0;
      id_seen_q  <= 1'b0;
      sig_ok_q   <= 1'b0;
      all_ff_q   <= 1'b1;
      done_o     <= 1'b0;
      found_o    <= 1'b0;
      onfi_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (seq_req) inflt_q <= 1'b1;
      if (poll_start) poll_run_q <= 1'b1;
      if (is_op && bus_ack) inflt_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q      <= ST_RST_CMD;
          inflt_q   <= 1'b0;
          att_q     <= '0;
          id_seen_q <= 1'b0;
          sig_ok_q  <= 1'b0;
          all_ff_q  <= 1'b1;
          found_o   <= 1'b0;
          onfi_o    <= 1'b0;
        end
        ST_RST_CMD:  if (bus_ack) st_q <= ST_RST_POLL;
        ST_RST_POLL: if (p_done) begin
          poll_run_q <= 1'b0;
          if (p_ok)                                  st_q <= ST_ID_CMD;
          else if (att_q == ATT_W'(RESET_POLLS - 1)) st_q <= ST_SIG_CMD;
          else                                       att_q <= att_q + 1'b1;
        end
        ST_ID_CMD:  if (bus_ack) st_q <= ST_ID_ADDR;
        ST_ID_ADDR: if (bus_ack) begin st_q <= ST_ID_RD; cnt_q <= '0; end
        ST_ID_RD: if (bus_ack) begin
          if (cnt_q == CNT_W'(1)) begin id_byte_q <= bus_rdata; id_seen_q <= 1'b1; end
          cnt_q <= cnt_q + 1'b1;
          if (last_sig) st_q <= ST_SIG_CMD;
        end
        ST_SIG_CMD:  if (bus_ack) st_q <= ST_SIG_ADDR;
        ST_SIG_ADDR: if (bus_ack) begin st_q <= ST_SIG_RD; cnt_q <= '0; sig_ok_q <= 1'b1; end
        ST_SIG_RD: if (bus_ack) begin
          sig_ok_q <= sig_ok_nx;
          cnt_q    <= cnt_q + 1'b1;
          if (last_sig) st_q <= sig_ok_nx ? ST_PP_CMD : ST_FINISH;
        end
        ST_PP_CMD:  if (bus_ack) st_q <= ST_PP_ADDR;
        ST_PP_ADDR: if (bus_ack) st_q <= ST_PP_POLL;
        ST_PP_POLL: if (p_done) begin poll_run_q <= 1'b0; st_q <= ST_PP_DOUT; end
        ST_PP_DOUT: if (bus_ack) begin st_q <= ST_PP_RD; cnt_q <= '0; all_ff_q <= 1'b1; end
        ST_PP_RD: if (bus_ack) begin
          all_ff_q <= all_ff_nx;
          cnt_q    <= cnt_q + 1'b1;
          if (last_page) st_q <= ST_FINISH;
        end
        default: begin
          done_o  <= 1'b1;
          onfi_o  <= sig_ok_q && !all_ff_q;
          found_o <= id_hit || (sig_ok_q && !all_ff_q);
          st_q    <= ST_IDLE;
        end
      endcase
    end
  end

  nand_bus_cycle u_bus (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (bus_req),
    .kind_i  (bus_kind),
    .wdata_i (bus_wdata),
    .ack_o   (bus_ack),
    .rdata_o (bus_rdata),
    .dq_o    (nand_dq_o),
    .dq_i    (nand_dq_i),
    .dq_oe_o (nand_dq_oe_o),
    .cle_o   (nand_cle_o),
    .ale_o   (nand_ale_o),
    .we_no   (nand_we_no),
    .re_no   (nand_re_no)
  );

  nand_status_poll #(.POLL_READS(POLL_READS)) u_poll (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (poll_start),
    .req_o   (p_req),
    .kind_o  (p_kind),
    .wdata_o (p_wdata),
    .ack_i   (bus_ack && is_poll),
    .rdy_i   (bus_rdata[6]),
    .fail_i  (bus_rdata[0]),
    .done_o  (p_done),
    .ok_o    (p_ok)
  );

  nand_param_capture #(.IDX_W(CNT_W)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cap_clr),
    .wr_i   (cap_wr),
    .idx_i  (cnt_q),
    .byte_i (bus_rdata),
    .geom_o (geom)
  );

  assign mfr_id_o        = geom.mfr;
  assign bus16_o         = geom.bus16;
  assign page_bytes_o    = geom.page_bytes;
  assign spare_bytes_o   = geom.spare_bytes;
  assign pages_per_blk_o = geom.pages_per_blk;
  assign blks_per_lun_o  = geom.blks_per_lun;
  assign lun_cnt_o       = geom.lun_cnt;
  assign ecc_bits_o      = geom.ecc_bits;
  assign model_o         = geom.model;
endmodule

// File: rtl/nand_probe_seq_chk.sv
module nand_probe_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        busy_i,
  input logic        done_o,
  input logic        found_o,
  input logic        onfi_o,
  input logic [7:0]  mfr_id_o,
  input logic [31:0] page_bytes_o,
  input logic        nand_we_no,
  input logic        nand_re_no,
  input logic        nand_cle_o,
  input logic        nand_ale_o,
  input logic        nand_dq_oe_o
);
  // R11
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  // R11
  latch_en_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  // R11
  read_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_re_no |-> !nand_dq_oe_o);
  // R12
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  onfi_found_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && onfi_o) |-> found_o);
  // R9
  fields_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !onfi_o) |-> (page_bytes_o == '0 && mfr_id_o == '0));
  // R2
  start_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (busy_i && !found_o && !onfi_o && mfr_id_o == '0));
endmodule

bind nand_probe_seq nand_probe_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .busy_i       (busy),
  .done_o       (done_o),
  .found_o      (found_o),
  .onfi_o       (onfi_o),
  .mfr_id_o     (mfr_id_o),
  .page_bytes_o (page_bytes_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/nand_probe_seq_test.sv
module nand_probe_seq_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic done_o, found_o, onfi_o, bus16_o;
  logic [7:0] mfr_id_o, lun_cnt_o, ecc_bits_o, model_o;
  logic [31:0] page_bytes_o, pages_per_blk_o, blks_per_lun_o;
  logic [15:0] spare_bytes_o;
  logic [7:0] nand_dq_o;
  logic [7:0] nand_dq_i;
  logic nand_dq_oe_o, nand_cle_o, nand_ale_o, nand_we_no, nand_re_no;

  always #5 clk = ~clk;

  nand_probe_seq #(.POLL_READS(4)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .done_o(done_o),
    .found_o(found_o), .onfi_o(onfi_o), .mfr_id_o(mfr_id_o), .bus16_o(bus16_o),
    .page_bytes_o(page_bytes_o), .spare_bytes_o(spare_bytes_o),
    .pages_per_blk_o(pages_per_blk_o), .blks_per_lun_o(blks_per_lun_o),
    .lun_cnt_o(lun_cnt_o), .ecc_bits_o(ecc_bits_o), .model_o(model_o),
    .nand_dq_o(nand_dq_o), .nand_dq_i(nand_dq_i), .nand_dq_oe_o(nand_dq_oe_o),
    .nand_cle_o(nand_cle_o), .nand_ale_o(nand_ale_o),
    .nand_we_no(nand_we_no), .nand_re_no(nand_re_no)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- device model ----------------
  localparam int M_NONE = 0, M_STAT = 1, M_IDW = 2, M_ID = 3, M_SIG = 4, M_PGW = 5, M_PAGE = 6;
  logic       m_present = 1'b1, m_onfi = 1'b1, m_blank = 1'b0;
  logic [7:0] m_dev_id = 8'hDA;
  int m_fail_polls = 0, m_busy_reads = 0;
  int mode = M_NONE, ptr = 0, n_stat = 0, stat_reads = 0;
  int n_cmds = 0, page_reads = 0;
  logic [7:0] cmd_log [128];
  int strobe_bad = 0;

  function automatic logic [7:0] pb(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(posedge nand_we_no) if (rst_ni === 1'b1) begin
    if (nand_cle_o === 1'b1) begin
      if (n_cmds < 128) cmd_log[n_cmds] = nand_dq_o;
      n_cmds++;
      ptr = 0;
      case (nand_dq_o)
        8'hFF: begin mode = M_NONE; n_stat = 0; end
        8'h70: begin mode = M_STAT; n_stat++; stat_reads = 0; end
        8'h90: mode = M_IDW;
        8'hEC: mode = M_PGW;
        8'h00: mode = M_PAGE;
        default: mode = M_NONE;
      endcase
    end else if (nand_ale_o === 1'b1) begin
      ptr = 0;
      if (mode == M_IDW) mode = (nand_dq_o == 8'h20) ? M_SIG : M_ID;
    end
  end

  always @(posedge nand_re_no) if (rst_ni === 1'b1) begin
    ptr++;
    if (mode == M_STAT) stat_reads++;
    if (mode == M_PAGE) page_reads++;
  end

  always_comb begin
    nand_dq_i = 8'h00;
    if (m_present) begin
      case (mode)
        M_STAT: nand_dq_i = (stat_reads < m_busy_reads) ? 8'h00 :
                            (n_stat <= m_fail_polls) ? 8'h41 : 8'h40;
        M_ID: case (ptr)
          0: nand_dq_i = 8'h2C;
          1: nand_dq_i = m_dev_id;
          2: nand_dq_i = 8'h90;
          default: nand_dq_i = 8'h95;
        endcase
        M_SIG: if (m_onfi) case (ptr)
          0: nand_dq_i = 8'h4F;
          1: nand_dq_i = 8'h4E;
          2: nand_dq_i = 8'h46;
          default: nand_dq_i = 8'h49;
        endcase
        M_PAGE: nand_dq_i = m_blank ? 8'hFF : pb(ptr);
        default: nand_dq_i = 8'h00;
      endcase
    end
  end

  // R11 bus discipline monitor
  always @(negedge clk) if (rst_ni) begin
    if ((!nand_we_no && !nand_re_no) || (nand_cle_o && nand_ale_o)) strobe_bad++;
  end

  // ---------------- helpers ----------------
  int done_cnt;
  logic r_found, r_onfi;

  function automatic int count_cmd(input logic [7:0] c);
    int n = 0;
    for (int i = 0; i < n_cmds && i < 128; i++) if (cmd_log[i] == c) n++;
    return n;
  endfunction

  function automatic int stat_before_id();
    int n = 0;
    for (int i = 0; i < n_cmds && i < 128; i++) begin
      if (cmd_log[i] == 8'h90) return n;
      if (cmd_log[i] == 8'h70) n++;
    end
    return n;
  endfunction

  function automatic bit param_order_ok();
    for (int i = 0; i + 2 < n_cmds && i + 2 < 128; i++)
      if (cmd_log[i] == 8'hEC && cmd_log[i+1] == 8'h70 && cmd_log[i+2] == 8'h00) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clear_log();
    n_cmds = 0; page_reads = 0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (done_o !== 1'b1 && guard < 20000) begin @(negedge clk); guard++; end
    r_found = found_o; r_onfi = onfi_o;
    done_cnt = (done_o === 1'b1) ? 1 : 0;
  endtask

  task automatic run_probe();
    clear_log();
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    wait_done();
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (done_o) done_cnt++; end
  endtask

  task automatic set_dev(input logic pres, input logic [7:0] id, input logic onfi,
                         input logic blank, input int fails, input int busyr);
    m_present = pres; m_dev_id = id; m_onfi = onfi; m_blank = blank;
    m_fail_polls = fails; m_busy_reads = busyr;
  endtask

  task automatic chk_fields_zero(input string req);
    chk(req, page_bytes_o, 0); chk(req, {24'h0, mfr_id_o}, 0);
    chk(req, pages_per_blk_o, 0); chk(req, {31'h0, bus16_o}, 0);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    chk("R1 done", {31'h0, done_o}, 0);
    chk("R1 found", {31'h0, found_o}, 0);
    chk("R1 onfi", {31'h0, onfi_o}, 0);
    chk("R1 we_n", {31'h0, nand_we_no}, 1);
    chk("R1 re_n", {31'h0, nand_re_no}, 1);
    chk("R1 cle/ale", {30'h0, nand_cle_o, nand_ale_o}, 0);
    chk_fields_zero("R1 fields");
  endtask

  task automatic t_full();
    set_dev(1, 8'hDA, 1, 0, 0, 0);
    run_probe();
    chk("R3 first cmd", {24'h0, cmd_log[0]}, 32'hFF);
    chk("R4 single poll", stat_before_id(), 1);
    chk("R5 found", {31'h0, r_found}, 1);
    chk("R10 onfi", {31'h0, r_onfi}, 1);
    chk("R7 page reads", page_reads, 116);
    chk("R7 order", {31'h0, param_order_ok()}, 1);
    chk("R8 mfr", {24'h0, mfr_id_o}, {24'h0, pb(64)});
    chk("R8 bus16", {31'h0, bus16_o}, {31'h0, pb(6) & 8'h01});
    chk("R8 page", page_bytes_o, {pb(83), pb(82), pb(81), pb(80)});
    chk("R8 spare", {16'h0, spare_bytes_o}, {16'h0, pb(85), pb(84)});
    chk("R8 ppb", pages_per_blk_o, {pb(95), pb(94), pb(93), pb(92)});
    chk("R8 bpl", blks_per_lun_o, {pb(99), pb(98), pb(97), pb(96)});
    chk("R8 luns", {24'h0, lun_cnt_o}, {24'h0, pb(100)});
    chk("R8 ecc", {24'h0, ecc_bits_o}, {24'h0, pb(112)});
    chk("R8 model", {24'h0, model_o}, {24'h0, pb(49)});
    chk("R12 done pulses", done_cnt, 1);
  endtask

  task automatic t_retry();
    set_dev(1, 8'hDA, 1, 0, 3, 2);
    run_probe();
    chk("R4 polls until ok", stat_before_id(), 4);
    chk("R4 found after retries", {31'h0, r_found}, 1);
  endtask

  task automatic t_unknown_onfi();
    set_dev(1, 8'h33, 1, 0, 0, 0);
    run_probe();
    chk("R10 found via signature", {31'h0, r_found}, 1);
    chk("R10 onfi", {31'h0, r_onfi}, 1);
  endtask

  task automatic t_no_sig();
    set_dev(1, 8'hF1, 0, 0, 0, 0);
    run_probe();
    chk("R5 found by id", {31'h0, r_found}, 1);
    chk("R6 onfi", {31'h0, r_onfi}, 0);
    chk("R6 no param cmd", count_cmd(8'hEC), 0);
    chk_fields_zero("R6 fields");
  endtask

  task automatic t_blank();
    set_dev(1, 8'h33, 1, 1, 0, 0);
    run_probe();
    chk("R9 found", {31'h0, r_found}, 0);
    chk("R9 onfi", {31'h0, r_onfi}, 0);
    chk("R9 page reads", page_reads, 116);
    chk_fields_zero("R9 fields");
  endtask

  task automatic t_absent();
    set_dev(0, 8'hDA, 1, 0, 0, 0);
    run_probe();
    chk("R4 poll limit", stat_before_id(), 60);
    chk("R5 id read skipped", count_cmd(8'h90), 1);
    chk("R4 found", {31'h0, r_found}, 0);
  endtask

  task automatic t_start_at_done();
    set_dev(1, 8'hDA, 1, 0, 0, 0);
    clear_log();
    @(negedge clk); start_i = 1'b1;
    wait_done();
    chk("R2 held start ignored", count_cmd(8'hFF), 1);
    chk("R2 fields before restart", {24'h0, mfr_id_o}, {24'h0, pb(64)});
    @(negedge clk);
    chk("R2 found cleared", {31'h0, found_o}, 0);
    chk("R2 mfr cleared", {24'h0, mfr_id_o}, 0);
    start_i = 1'b0;
    wait_done();
    chk("R2 restart ran", count_cmd(8'hFF), 2);
    chk("R12 second done", done_cnt, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R12 watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_full();
    t_retry();
    t_unknown_onfi();
    t_no_sig();
    t_blank();
    t_absent();
    t_start_at_done();
    repeat (5) @(negedge clk);
    chk("R11 strobe overlap", strobe_bad, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule